// File: doc/BRIEF.md
# Pseudo-SRAM Power-State Controller

This block is the control core of a pseudo-SRAM that hides its own refresh. It tracks the device through its power-up wait, idle standby, active access, the low-power window opened by the sleep pin, partial-refresh standby, deep power-down and the recovery that follows it. A microsecond strobe from the chip timebase drives every time rule, so all waits are counted in ticks rather than in clock cycles.

The sleep pin has two uses. With chip enable low it opens a window in which a write-enable pulse loads an eight-bit configuration word from the low address bits. With chip enable high it sends the device into a low-power state. The configuration decides which state that is, and which quarters of the array keep their contents. A four-bit retention mask records, per quarter of the address space, whether stored data has survived. A busy flag covers the wait periods, and an error pulse reports requests that were refused.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: While reset is high and on its release, the state is INIT (code 0), busy is 1, retain is 0000 and req_err is 0. The configuration reads as its defaults: page_en 0, temp_sel 11, dpd_dis 1, rms_sel 0, top_sel 0, part_sel 00.
- R2: INIT moves to STBY (code 1) only after PWRUP_US ticks have been counted with ce_n high. A cycle with ce_n low restarts the count. Entering STBY from INIT sets retain to 1111.
- R3: In STBY, ce_n low with zz_n high and lb_n or hb_n low gives ACTIVE (code 2). ce_n low with both byte enables high stays in STBY. ACTIVE with zz_n high and ce_n high returns to STBY.
- R4: zz_n low in STBY or ACTIVE gives ZZWIN (code 3) on the next cycle. zz_n high in ZZWIN returns to STBY.
- R5: In ZZWIN with ce_n low, a falling edge of we_n loads the configuration from addr[7:0]. The fields are bit 7 page_en, bits 6:5 temp_sel, bit 4 dpd_dis, bit 3 rms_sel, bit 2 top_sel and bits 1:0 part_sel. The load takes place only when at least ZZWE_MIN_US ticks have passed in ZZWIN and addr[19:8] is zero.
- R6: A we_n falling edge that comes too early, or that carries nonzero reserved bits, leaves the configuration unchanged and pulses req_err one cycle later. The configuration changes in no other state, except on exit from DPD.
- R7: In ZZWIN, with ce_n high and dpd_dis 0, the state moves to DPD (code 5) after DPD_MIN_US ticks. On entry retain becomes 0000. If zz_n rises before that, the state returns to STBY with retain unchanged.
- R8: In ZZWIN, ce_n high with dpd_dis 1 gives PAR (code 4) on the next cycle, and retain is ANDed with the region mask. Bit q of the mask stands for addr[19:18]==q. part_sel 00 gives all quarters. Settings 01, 10 and 11 keep three, two or one quarters, counted from quarter 0 when top_sel is 0 and from quarter 3 when top_sel is 1. In PAR, ce_n low returns to ZZWIN and zz_n high returns to STBY.
- R9: In DPD, zz_n high moves to RECOV (code 6) and restores the default configuration. RECOV moves to STBY after RECOV_US ticks, with retain 1111.
- R10: With rms_sel 1, leaving ZZWIN or PAR for STBY ANDs retain with the region mask.
- R11: An access request (ce_n low, zz_n high, lb_n or hb_n low) in INIT, DPD or RECOV never leads to ACTIVE and pulses req_err one cycle later.
- R12: busy is 1 in INIT and RECOV and 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| ce_n | input | 1 | Chip enable, active low |
| zz_n | input | 1 | Sleep pin, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Low byte enable, active low |
| hb_n | input | 1 | High byte enable, active low |
| addr | input | ADDR_W | Address; bits 7:0 carry the configuration word |
| pwr_state | output | 3 | Current power state code |
| page_en | output | 1 | Page-mode read enable field |
| temp_sel | output | 2 | Refresh temperature field |
| dpd_dis | output | 1 | Deep power-down disable field |
| rms_sel | output | 1 | Reduced-size (1) or partial-refresh (0) select |
| top_sel | output | 1 | Region anchored at the top (1) or bottom (0) |
| part_sel | output | 2 | Region size field |
| retain | output | 4 | Per-quarter data retention flags |
| busy | output | 1 | Access blocked during power-up or recovery |
| req_err | output | 1 | One-cycle pulse for a refused request or load |

## Verification
The retention mask after a partial-refresh entry is the hardest result to reach. A value can only be seen once all four quarters have been made valid again, and that takes either a full power-up or a deep power-down with its recovery. For each point of the sweep over region size, anchor side and the partial or reduced-size choice, the bench resets the block, waits out the power-up, loads the configuration through the sleep window and then either raises chip enable or lifts the sleep pin. Deep power-down entry needs a prior load that clears the disable bit, followed by a tick count that is checked on both sides of the threshold.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [2:0] {
        PS_INIT   = 3'd0,
        PS_STBY   = 3'd1,
        PS_ACTIVE = 3'd2,
        PS_ZZWIN  = 3'd3,
        PS_PAR    = 3'd4,
        PS_DPD    = 3'd5,
        PS_RECOV  = 3'd6
    } pwr_state_e;

    typedef struct packed {
        logic       page_en;
        logic [1:0] temp_sel;
        logic       dpd_dis;
        logic       rms_sel;
        logic       top_sel;
        logic [1:0] part_sel;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{
        page_en:  1'b0,
        temp_sel: 2'b11,
        dpd_dis:  1'b1,
        rms_sel:  1'b0,
        top_sel:  1'b0,
        part_sel: 2'b00
    };

    // Quarters of the array kept alive by a configuration; bit q = addr[19:18]==q
    function automatic logic [3:0] region_mask(cfg_t c);
        logic [3:0] m;
        case (c.part_sel)
            2'b00:   m = 4'b1111;
            2'b01:   m = c.top_sel ? 4'b1110 : 4'b0111;
            2'b10:   m = c.top_sel ? 4'b1100 : 4'b0011;
            default: m = c.top_sel ? 4'b1000 : 4'b0001;
        endcase
        return m;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lp_us_timer.sv
module lp_us_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/lp_cfg_reg.sv
module lp_cfg_reg
    import psram_pwr_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int GAP_W   = 8,
    parameter int GAP_MIN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_window,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GAP_W-1:0]  gap_cnt,
    input  logic              restore,
    output cfg_t              cfg,
    output logic              reject
);
    localparam logic [GAP_W-1:0] GAP_L = GAP_W'(GAP_MIN);

    logic we_q;
    logic we_fall;
    logic rsvd_ok;
    logic load_req;
    logic accept;

    generate
        if (ADDR_W > CFG_W) begin : g_rsvd
            assign rsvd_ok = (addr[ADDR_W-1:CFG_W] == '0);
        end else begin : g_no_rsvd
            assign rsvd_ok = 1'b1;
        end
    endgenerate

    assign we_fall  = we_q && !we_n;
    assign load_req = in_window && !ce_n && we_fall;
    assign accept   = load_req && rsvd_ok && (gap_cnt >= GAP_L);
    assign reject   = load_req && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            cfg  <= CFG_DEFAULT;
        end else begin
            we_q <= we_n;
            if (restore) begin
                cfg <= CFG_DEFAULT;
            end else if (accept) begin
                cfg <= cfg_t'(addr[CFG_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/lp_pwr_fsm.sv
module lp_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int PH_W       = 8,
    parameter int HD_W       = 4,
    parameter int PWRUP_US   = 200,
    parameter int RECOV_US   = 200,
    parameter int DPD_MIN_US = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            zz_n,
    input  logic            be_req,
    input  logic            dpd_dis,
    input  logic [PH_W-1:0] ph_cnt,
    input  logic [HD_W-1:0] hold_cnt,
    output pwr_state_e      state,
    output pwr_state_e      nxt
);
    localparam logic [PH_W-1:0] PWRUP_L = PH_W'(PWRUP_US);
    localparam logic [PH_W-1:0] RECOV_L = PH_W'(RECOV_US);
    localparam logic [HD_W-1:0] HOLD_L  = HD_W'(DPD_MIN_US);

    always_comb begin
        nxt = state;
        case (state)
            PS_INIT: begin
                if (ce_n && (ph_cnt >= PWRUP_L)) nxt = PS_STBY;
            end
            PS_STBY: begin
                if (!zz_n)                nxt = PS_ZZWIN;
                else if (!ce_n && be_req) nxt = PS_ACTIVE;
            end
            PS_ACTIVE: begin
                if (!zz_n)     nxt = PS_ZZWIN;
                else if (ce_n) nxt = PS_STBY;
            end
            PS_ZZWIN: begin
                if (zz_n)                                 nxt = PS_STBY;
                else if (ce_n && dpd_dis)                 nxt = PS_PAR;
                else if (ce_n && (hold_cnt >= HOLD_L))    nxt = PS_DPD;
            end
            PS_PAR: begin
                if (zz_n)       nxt = PS_STBY;
                else if (!ce_n) nxt = PS_ZZWIN;
            end
            PS_DPD: begin
                if (zz_n) nxt = PS_RECOV;
            end
            PS_RECOV: begin
                if (ph_cnt >= RECOV_L) nxt = PS_STBY;
            end
            default: nxt = PS_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_INIT;
        else     state <= nxt;
    end
endmodule

// File: rtl/lp_retain.sv
module lp_retain
    import psram_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_state_e state,
    input  pwr_state_e nxt,
    input  cfg_t       cfg,
    output logic [3:0] retain
);
    logic [3:0] mask;
    logic       wake_done;
    logic       par_entry;
    logic       zz_exit;

    assign mask      = region_mask(cfg);
    assign wake_done = (nxt == PS_STBY) && ((state == PS_INIT) || (state == PS_RECOV));
    assign par_entry = (nxt == PS_PAR) && (state != PS_PAR);
    assign zz_exit   = (nxt == PS_STBY) && ((state == PS_ZZWIN) || (state == PS_PAR));

    always_ff @(posedge clk) begin
        if (rst) begin
            retain <= 4'b0000;
        end else if (wake_done) begin
            retain <= 4'b1111;
        end else if (nxt == PS_DPD) begin
            retain <= 4'b0000;
        end else if (par_entry || (zz_exit && cfg.rms_sel)) begin
            retain <= retain & mask;
        end
    end
endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
    import psram_pwr_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PWRUP_US    = 200,
    parameter int RECOV_US    = 200,
    parameter int DPD_MIN_US  = 10,
    parameter int ZZWE_MIN_US = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              ce_n,
    input  logic              zz_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              hb_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        pwr_state,
    output logic              page_en,
    output logic [1:0]        temp_sel,
    output logic              dpd_dis,
    output logic              rms_sel,
    output logic              top_sel,
    output logic [1:0]        part_sel,
    output logic [3:0]        retain,
    output logic              busy,
    output logic              req_err
);
    localparam int PH_MAX = max3(PWRUP_US, RECOV_US, ZZWE_MIN_US);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int HD_W   = $clog2(DPD_MIN_US + 1);

    pwr_state_e      state;
    pwr_state_e      nxt;
    cfg_t            cfg;
    logic [PH_W-1:0] ph_cnt;
    logic [HD_W-1:0] hold_cnt;
    logic            ph_clr;
    logic            hold_clr;
    logic            be_req;
    logic            acc_req;
    logic            blocked;
    logic            load_reject;
    logic            err_q;

    assign be_req   = !lb_n || !hb_n;
    assign acc_req  = !ce_n && zz_n && be_req;
    assign blocked  = (state == PS_INIT) || (state == PS_DPD) || (state == PS_RECOV);
    assign ph_clr   = (state != nxt) || ((state == PS_INIT) && !ce_n);
    assign hold_clr = !((state == PS_ZZWIN) && ce_n && !zz_n);

    lp_us_timer #(.W(PH_W)) u_ph_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (ph_clr),
        .inc   (us_tick),
        .count (ph_cnt)
    );

    lp_us_timer #(.W(HD_W)) u_hold_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (hold_clr),
        .inc   (us_tick),
        .count (hold_cnt)
    );

    lp_pwr_fsm #(
        .PH_W       (PH_W),
        .HD_W       (HD_W),
        .PWRUP_US   (PWRUP_US),
        .RECOV_US   (RECOV_US),
        .DPD_MIN_US (DPD_MIN_US)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .zz_n     (zz_n),
        .be_req   (be_req),
        .dpd_dis  (cfg.dpd_dis),
        .ph_cnt   (ph_cnt),
        .hold_cnt (hold_cnt),
        .state    (state),
        .nxt      (nxt)
    );

    lp_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .GAP_W   (PH_W),
        .GAP_MIN (ZZWE_MIN_US)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .in_window (state == PS_ZZWIN),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .gap_cnt   (ph_cnt),
        .restore   ((state == PS_DPD) && zz_n),
        .cfg       (cfg),
        .reject    (load_reject)
    );

    lp_retain u_retain (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .nxt    (nxt),
        .cfg    (cfg),
        .retain (retain)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= load_reject || (acc_req && blocked);
    end

    assign pwr_state = state;
    assign page_en   = cfg.page_en;
    assign temp_sel  = cfg.temp_sel;
    assign dpd_dis   = cfg.dpd_dis;
    assign rms_sel   = cfg.rms_sel;
    assign top_sel   = cfg.top_sel;
    assign part_sel  = cfg.part_sel;
    assign busy      = (state == PS_INIT) || (state == PS_RECOV);
    assign req_err   = err_q;
endmodule

// File: rtl/psram_pwr_ctrl_chk.sv
module psram_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       zz_n,
    input logic [2:0] pwr_state,
    input logic [7:0] cfg_word,
    input logic [3:0] retain
);
    localparam logic [2:0] S_INIT = 3'd0, S_STBY = 3'd1, S_ACT = 3'd2, S_WIN = 3'd3,
                           S_PAR = 3'd4, S_DPD = 3'd5, S_REC = 3'd6;

    // R3
    act_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_ACT && ce_n && zz_n) |=> (pwr_state == S_STBY));

    // R4
    zz_enter_chk: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == S_STBY || pwr_state == S_ACT) && !zz_n) |=> (pwr_state == S_WIN));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != S_WIN && pwr_state != S_DPD) |=> $stable(cfg_word));

    // R7
    dpd_retain_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_DPD) |-> (retain == 4'b0000));

    // R8
    par_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_WIN && ce_n && !zz_n && cfg_word[4]) |=> (pwr_state == S_PAR));

    // R9
    dpd_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_DPD && zz_n) |=> (pwr_state == S_REC && cfg_word == 8'h70));

    // R11
    recov_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_REC) |=> (pwr_state == S_REC || pwr_state == S_STBY));

    // R2
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == S_INIT && !ce_n) |=> (pwr_state == S_INIT));
endmodule

bind psram_pwr_ctrl psram_pwr_ctrl_chk u_pwr_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .zz_n      (zz_n),
    .pwr_state (pwr_state),
    .cfg_word  ({page_en, temp_sel, dpd_dis, rms_sel, top_sel, part_sel}),
    .retain    (retain)
);

// File: tb/test_psram_pwr_ctrl.sv
module test_psram_pwr_ctrl;
    localparam int PWRUP = 3;
    localparam int RECOV = 2;
    localparam int DMIN  = 4;
    localparam int GAP   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        ce_n = 1'b1;
    logic        zz_n = 1'b1;
    logic        we_n = 1'b1;
    logic        lb_n = 1'b1;
    logic        hb_n = 1'b1;
    logic [19:0] addr = '0;
    logic [2:0]  pwr_state;
    logic        page_en, dpd_dis, rms_sel, top_sel, busy, req_err;
    logic [1:0]  temp_sel, part_sel;
    logic [3:0]  retain;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    psram_pwr_ctrl #(
        .ADDR_W(20), .PWRUP_US(PWRUP), .RECOV_US(RECOV),
        .DPD_MIN_US(DMIN), .ZZWE_MIN_US(GAP)
    ) i_psram_pwr_ctrl (
        .clk(clk), .rst(rst), .us_tick(us_tick), .ce_n(ce_n), .zz_n(zz_n),
        .we_n(we_n), .lb_n(lb_n), .hb_n(hb_n), .addr(addr),
        .pwr_state(pwr_state), .page_en(page_en), .temp_sel(temp_sel),
        .dpd_dis(dpd_dis), .rms_sel(rms_sel), .top_sel(top_sel),
        .part_sel(part_sel), .retain(retain), .busy(busy), .req_err(req_err)
    );

    function automatic logic [7:0] cfg_now();
        return {page_en, temp_sel, dpd_dis, rms_sel, top_sel, part_sel};
    endfunction

    function automatic logic [3:0] exp_mask(int part, int top);
        int n;
        n = (part == 0) ? 4 : 4 - part;
        return 4'(((1 << n) - 1) << (top != 0 ? 4 - n : 0));
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            step();
            us_tick = 1'b0;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic power_up();
        rst = 1'b1; ce_n = 1'b1; zz_n = 1'b1; we_n = 1'b1;
        lb_n = 1'b1; hb_n = 1'b1; addr = '0;
        step(); step();
        rst = 1'b0;
        ticks(PWRUP);
        step();
    endtask

    task automatic load_cfg(input logic [19:0] a);
        addr = a; we_n = 1'b0;
        step();
        we_n = 1'b1;
        step();
    endtask

    initial begin
        // R1 reset state
        step(); step();
        check("R1", "state", 32'(pwr_state), 0);
        check("R1", "busy", 32'(busy), 1);
        check("R1", "cfg", 32'(cfg_now()), 32'h70);
        check("R1", "retain", 32'(retain), 0);
        check("R1", "req_err", 32'(req_err), 0);

        // R2 power-up wait with a restart
        rst = 1'b0;
        ticks(PWRUP - 1);
        step();
        check("R2", "state before limit", 32'(pwr_state), 0);
        ce_n = 1'b0; lb_n = 1'b0;
        step();
        check("R11", "err in INIT", 32'(req_err), 1);
        check("R11", "state in INIT", 32'(pwr_state), 0);
        ce_n = 1'b1; lb_n = 1'b1;
        step();
        check("R11", "err clears", 32'(req_err), 0);
        ticks(PWRUP - 1);
        step();
        check("R2", "state after restart", 32'(pwr_state), 0);
        check("R12", "busy in INIT", 32'(busy), 1);
        ticks(1);
        step();
        check("R2", "state STBY", 32'(pwr_state), 1);
        check("R2", "retain full", 32'(retain), 4'hF);
        check("R12", "busy in STBY", 32'(busy), 0);

        // R3 active entry and exit
        ce_n = 1'b0;
        step();
        check("R3", "no byte enable stays", 32'(pwr_state), 1);
        hb_n = 1'b0;
        step();
        check("R3", "ACTIVE", 32'(pwr_state), 2);
        ce_n = 1'b1; hb_n = 1'b1;
        step();
        check("R3", "back to STBY", 32'(pwr_state), 1);

        // R4/R5/R6 register window
        ce_n = 1'b0; zz_n = 1'b0;
        step();
        check("R4", "ZZWIN", 32'(pwr_state), 3);
        load_cfg(20'h000A6);
        check("R6", "early load ignored", 32'(cfg_now()), 32'h70);
        ticks(GAP);
        addr = 20'h100A6; we_n = 1'b0;
        step();
        check("R6", "reserved load ignored", 32'(cfg_now()), 32'h70);
        check("R6", "reserved load err", 32'(req_err), 1);
        we_n = 1'b1;
        step();
        load_cfg(20'h000A6);
        check("R5", "cfg loaded", 32'(cfg_now()), 32'hA6);
        check("R5", "page_en", 32'(page_en), 1);
        check("R5", "temp_sel", 32'(temp_sel), 1);
        check("R5", "part_sel", 32'(part_sel), 2);

        // R7 short hold keeps data
        ce_n = 1'b1;
        ticks(DMIN - 1);
        step();
        check("R7", "short hold stays", 32'(pwr_state), 3);
        zz_n = 1'b1;
        step();
        check("R4", "ZZ high to STBY", 32'(pwr_state), 1);
        check("R7", "retain kept", 32'(retain), 4'hF);

        // R7 deep power-down entry
        zz_n = 1'b0;
        step();
        ticks(DMIN);
        check("R7", "not yet DPD", 32'(pwr_state), 3);
        step();
        check("R7", "DPD", 32'(pwr_state), 5);
        check("R7", "retain lost", 32'(retain), 0);
        check("R12", "busy in DPD", 32'(busy), 0);

        // R9/R11 exit and recovery
        zz_n = 1'b1; ce_n = 1'b0; lb_n = 1'b0;
        step();
        check("R9", "RECOV", 32'(pwr_state), 6);
        check("R9", "cfg default", 32'(cfg_now()), 32'h70);
        check("R11", "err in DPD", 32'(req_err), 1);
        check("R12", "busy in RECOV", 32'(busy), 1);
        step();
        check("R11", "RECOV refuses access", 32'(pwr_state), 6);
        check("R11", "err in RECOV", 32'(req_err), 1);
        ce_n = 1'b1; lb_n = 1'b1;
        ticks(RECOV);
        check("R9", "still RECOV", 32'(pwr_state), 6);
        step();
        check("R9", "STBY after recovery", 32'(pwr_state), 1);
        check("R9", "retain full", 32'(retain), 4'hF);

        // R8/R10 sweep of region settings
        for (int rms = 0; rms < 2; rms++) begin
            for (int top = 0; top < 2; top++) begin
                for (int part = 0; part < 4; part++) begin
                    logic [7:0] v;
                    logic [3:0] m;
                    v = {1'b0, 2'b11, 1'b1, 1'(rms), 1'(top), 2'(part)};
                    m = exp_mask(part, top);
                    power_up();
                    ce_n = 1'b0; zz_n = 1'b0;
                    step();
                    ticks(GAP);
                    load_cfg({12'h000, v});
                    check("R5", "sweep cfg", 32'(cfg_now()), 32'(v));
                    if (rms == 0) begin
                        ce_n = 1'b1;
                        step();
                        check("R8", "PAR", 32'(pwr_state), 4);
                        check("R8", "PAR retain", 32'(retain), 32'(m));
                        ce_n = 1'b0;
                        step();
                        check("R8", "PAR to window", 32'(pwr_state), 3);
                        ce_n = 1'b1;
                        step();
                        zz_n = 1'b1;
                        step();
                        check("R8", "PAR exit STBY", 32'(pwr_state), 1);
                        check("R8", "retain after exit", 32'(retain), 32'(m));
                    end else begin
                        zz_n = 1'b1;
                        step();
                        check("R10", "STBY", 32'(pwr_state), 1);
                        check("R10", "reduced retain", 32'(retain), 32'(m));
                    end
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule